// File: doc/BRIEF.md
# Add/Subtract and Compare Unit with Sticky Carry and Equal Flags

This unit adds, subtracts and compares two words of a configurable width. It holds two 1-bit flags, carry and equal, which keep their value until an instruction that is allowed to change them executes. In each cycle the execute stage presents two operands, an opcode and an issue strobe. It also presents two enables, decoded elsewhere, which say whether the instruction may change carry or equal. The unit returns the result and a write-enable for it. Compare opcodes run through the same subtract datapath, but they never request a write-back.

The flags cannot be read directly. Conditional execution sees them only through the condition outputs carry, equal and not-equal. A fourth condition reports whether the first operand is all zero, and it ignores both flags. The halfword extract and insert logic can also write the carry flag through a separate strobe. When an arithmetic carry update happens in the same cycle, the arithmetic update wins.

Top module: `addcmp_flags`

## Requirements
- R1: Opcode 2'b00 (ADD) gives result a+b modulo 2^WIDTH with write-enable high. When issued with carry update enabled, carry becomes the carry out of the top bit: on 16 bits 5678h+CDEFh sets it and 5678h+1234h clears it.
- R2: Opcode 2'b01 (SUB) gives result a−b with write-enable high. Carry becomes 1 when no borrow occurs (a ≥ b unsigned): 3−4 clears it, while 4−4 and 5−4 set it.
- R3: Opcode 2'b10 (unsigned compare) writes no result. Carry becomes 1 exactly when a < b unsigned, so comparing a value with itself clears carry and comparing 0 with a nonzero value sets it.
- R4: Opcode 2'b11 (signed compare) writes no result. Carry becomes 1 exactly when a < b in two's-complement order (for example 8000h < 7FFFh).
- R5: result_we_o is high only in a cycle with issue_i high and an ADD or SUB opcode.
- R6: Carry changes only on a clock edge where issue_i and carry_upd_i are both high (arithmetic value), or where hw_carry_we_i is high (value hw_carry_i). The arithmetic update has priority. Otherwise carry holds for any number of cycles.
- R7: Equal changes only on an edge where issue_i and equal_upd_i are both high. It then becomes 1 exactly when a_i and b_i are bitwise identical. Otherwise it holds.
- R8: cond_carry_o shows the carry flag, cond_eq_o shows the equal flag, and cond_ne_o is the inverse of cond_eq_o.
- R9: cond_zero_o is 1 exactly when a_i is all zero, whatever the state of the flags.
- R10: A synchronous reset clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Instruction executes this cycle |
| op_i | input | 2 | 00 ADD, 01 SUB, 10 unsigned compare, 11 signed compare |
| a_i | input | WIDTH | First operand, also the zero-test operand |
| b_i | input | WIDTH | Second operand |
| carry_upd_i | input | 1 | Instruction may change carry |
| equal_upd_i | input | 1 | Instruction may change equal |
| hw_carry_we_i | input | 1 | Halfword extract/insert writes carry |
| hw_carry_i | input | 1 | Carry value from halfword extract/insert |
| result_o | output | WIDTH | Sum or difference |
| result_we_o | output | 1 | Result write-back request |
| cond_carry_o | output | 1 | Carry condition |
| cond_eq_o | output | 1 | Equal condition |
| cond_ne_o | output | 1 | Not-equal condition |
| cond_zero_o | output | 1 | First operand is zero |

## Verification
The bench builds the unit with WIDTH = 16. At this width the hexadecimal addition and subtraction examples can be replayed exactly. The width also brings the signed boundary between 8000h and 7FFFh within reach, where the unsigned and signed compares disagree. The hold behaviour, the priority between the halfword carry strobe and the arithmetic update, and a mid-run reset are exercised at the same width.

// File: rtl/addcmp_flags.sv
module addcmp_flags #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_upd_i,
  input  logic             equal_upd_i,
  input  logic             hw_carry_we_i,
  input  logic             hw_carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_we_o,
  output logic             cond_carry_o,
  output logic             cond_eq_o,
  output logic             cond_ne_o,
  output logic             cond_zero_o
);
  localparam int MSB = WIDTH - 1;

  logic             subtract;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic             ovf, signed_lt, carry_new, same;
  logic             carry_q, equal_q;

  assign subtract  = (op_i != 2'b00);
  assign b_eff     = subtract ? ~b_i : b_i;
  assign sum       = {1'b0, a_i} + {1'b0, b_eff} + (WIDTH+1)'(subtract);
  assign ovf       = (a_i[MSB] ^ b_i[MSB]) & (sum[MSB] ^ a_i[MSB]);
  assign signed_lt = sum[MSB] ^ ovf;
  assign same      = &(~(a_i ^ b_i));

  always_comb begin
    case (op_i)
      2'b10:   carry_new = ~sum[WIDTH];
      2'b11:   carry_new = signed_lt;
      default: carry_new = sum[WIDTH];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      equal_q <= 1'b0;
    end else begin
      if (issue_i && carry_upd_i) carry_q <= carry_new;
      else if (hw_carry_we_i)     carry_q <= hw_carry_i;
      if (issue_i && equal_upd_i) equal_q <= same;
    end
  end

  assign result_o     = sum[MSB:0];
  assign result_we_o  = issue_i & ~op_i[1];
  assign cond_carry_o = carry_q;
  assign cond_eq_o    = equal_q;
  assign cond_ne_o    = ~equal_q;
  assign cond_zero_o  = ~|a_i;

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!cond_carry_o && !cond_eq_o));

  assert_add_carry_R1: assert property (@(posedge clk) disable iff (rst)
    (issue_i && carry_upd_i && op_i == 2'b00) |=>
      (cond_carry_o == ($past(result_o) < $past(a_i))));

  assert_sub_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_i && carry_upd_i && op_i == 2'b01) |=>
      (cond_carry_o == ($past(a_i) >= $past(b_i))));

  assert_cmpu_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_i && carry_upd_i && op_i == 2'b10) |=>
      (cond_carry_o == ($past(a_i) < $past(b_i))));

  assert_cmps_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_i && carry_upd_i && op_i == 2'b11) |=>
      (cond_carry_o == ($signed($past(a_i)) < $signed($past(b_i)))));

  assert_no_cmp_writeback_R5: assert property (@(posedge clk) disable iff (rst)
    (!issue_i || op_i[1]) |-> !result_we_o);

  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!(issue_i && carry_upd_i) && !hw_carry_we_i) |=> $stable(cond_carry_o));

  assert_equal_update_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_i && equal_upd_i) |=> (cond_eq_o == ($past(a_i) == $past(b_i))));

  assert_equal_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(issue_i && equal_upd_i) |=> $stable(cond_eq_o));
endmodule

// File: tb/addcmp_flags_test.sv
module addcmp_flags_test;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1, issue = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] a = '0, b = '0;
  logic cu = 1'b0, eu = 1'b0, hwe = 1'b0, hwv = 1'b0;
  logic [W-1:0] res;
  logic we, c_carry, c_eq, c_ne, c_zero;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  addcmp_flags #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .a_i(a), .b_i(b),
    .carry_upd_i(cu), .equal_upd_i(eu), .hw_carry_we_i(hwe), .hw_carry_i(hwv),
    .result_o(res), .result_we_o(we), .cond_carry_o(c_carry),
    .cond_eq_o(c_eq), .cond_ne_o(c_ne), .cond_zero_o(c_zero));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic exec(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y,
                      logic cupd, logic eupd);
    @(negedge clk);
    issue = 1'b1; op = o; a = x; b = y; cu = cupd; eu = eupd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    issue = 1'b0; cu = 1'b0; eu = 1'b0; hwe = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10 carry after reset", c_carry, 0);
    chk("R10 equal after reset", c_eq, 0);
    chk("R8 ne after reset", c_ne, 1);
  endtask

  task automatic t_add();
    exec(2'b00, 16'h5678, 16'hCDEF, 1, 0);
    chk("R1 sum", res, 16'h2467);
    chk("R5 add we", we, 1);
    idle();
    chk("R1 carry set", c_carry, 1);
    exec(2'b00, 16'h5678, 16'h1234, 1, 0);
    chk("R1 sum2", res, 16'h68AC);
    idle();
    chk("R1 carry clear", c_carry, 0);
  endtask

  task automatic t_sub();
    exec(2'b01, 16'd3, 16'd4, 1, 0);
    chk("R2 diff 3-4", res, 16'hFFFF);
    chk("R5 sub we", we, 1);
    idle();
    chk("R2 carry 3-4", c_carry, 0);
    exec(2'b01, 16'd4, 16'd4, 1, 0);
    chk("R2 diff 4-4", res, 16'h0000);
    idle();
    chk("R2 carry 4-4", c_carry, 1);
    exec(2'b01, 16'd5, 16'd4, 1, 0);
    chk("R2 diff 5-4", res, 16'h0001);
    idle();
    chk("R2 carry 5-4", c_carry, 1);
  endtask

  task automatic t_cmpu();
    exec(2'b10, 16'h1234, 16'h1234, 1, 0);
    chk("R3 cmpu no we", we, 0);
    idle();
    chk("R3 self compare clears", c_carry, 0);
    exec(2'b10, 16'h0000, 16'h0100, 1, 0);
    idle();
    chk("R3 zero vs nonzero sets", c_carry, 1);
    exec(2'b10, 16'h8000, 16'h7FFF, 1, 0);
    idle();
    chk("R3 unsigned 8000 vs 7FFF", c_carry, 0);
  endtask

  task automatic t_cmps();
    exec(2'b11, 16'h8000, 16'h7FFF, 1, 0);
    chk("R4 cmps no we", we, 0);
    idle();
    chk("R4 signed 8000 < 7FFF", c_carry, 1);
    exec(2'b11, 16'h7FFF, 16'h8000, 1, 0);
    idle();
    chk("R4 signed 7FFF !< 8000", c_carry, 0);
    exec(2'b11, 16'hFFFE, 16'hFFFF, 1, 0);
    idle();
    chk("R4 signed -2 < -1", c_carry, 1);
  endtask

  task automatic t_hold();
    exec(2'b00, 16'h0001, 16'h0001, 0, 0);
    idle();
    chk("R6 no update keeps carry", c_carry, 1);
    exec(2'b00, 16'h1, 16'h1, 1, 0);
    idle();
    chk("R6 add clears", c_carry, 0);
    exec(2'b00, 16'hFFFF, 16'h0001, 0, 0);
    chk("R5 issued add we", we, 1);
    repeat (5) idle();
    chk("R6 held over idle cycles", c_carry, 0);
    chk("R5 idle no we", we, 0);
    @(negedge clk); hwe = 1'b1; hwv = 1'b1;
    idle();
    chk("R6 halfword strobe sets", c_carry, 1);
    exec(2'b00, 16'h1, 16'h1, 1, 0);
    hwe = 1'b1; hwv = 1'b1;
    idle();
    chk("R6 arithmetic wins", c_carry, 0);
  endtask

  task automatic t_equal();
    exec(2'b10, 16'hA5A5, 16'hA5A5, 0, 1);
    idle();
    chk("R7 equal set", c_eq, 1);
    chk("R8 ne low", c_ne, 0);
    exec(2'b10, 16'hA5A5, 16'hA5A4, 0, 0);
    idle();
    chk("R7 equal held", c_eq, 1);
    exec(2'b00, 16'hA5A5, 16'h25A5, 0, 1);
    idle();
    chk("R7 equal cleared", c_eq, 0);
    chk("R8 ne high", c_ne, 1);
  endtask

  task automatic t_zero();
    exec(2'b10, 16'h0000, 16'h0000, 1, 1);
    chk("R9 zero operand", c_zero, 1);
    idle();
    chk("R9 zero with flags 0/1", c_zero, 1);
    a = 16'h0100; #1;
    chk("R9 nonzero operand", c_zero, 0);
    chk("R8 carry pin", c_carry, 0);
  endtask

  task automatic t_reset_mid();
    exec(2'b10, 16'h0, 16'h5, 1, 1);
    idle();
    chk("R3 setup carry", c_carry, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk("R10 carry cleared", c_carry, 0);
    chk("R10 equal cleared", c_eq, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    t_reset();
    t_add();
    t_sub();
    t_cmpu();
    t_cmps();
    t_hold();
    t_equal();
    t_zero();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule